// File: doc/BRIEF.md
# Bus Cycle Retry and Halt Controller

This controller sequences external bus cycles for a single internal requester and resolves the termination inputs that arrive while a cycle runs. A cycle ends normally on the port acknowledge, or it ends early on a bus error. When a bus error comes together with halt, the cycle is retried. When bus request also comes in that clock, the cycle is rerun after the bus has been lent to another master. Halt on its own stops the bus at the next cycle boundary, which gives cycle-by-cycle stepping. A bus error during exception processing is a double fault, and it freezes the controller until reset.

The requester holds `req_valid` with the cycle attributes until the controller accepts them. Acceptance shows as the address strobe rising. A `done_o` or `err_o` pulse reports how the cycle ended. To keep a locked read-modify-write sequence together, the requester keeps `req_valid` and `req_lock` high from one cycle to the next. The bus error, halt and bus request inputs each pass through a two-flop synchronizer. The acknowledge and the exception flag are taken as synchronous. `exc_busy` stands in for the processor core's exception state.

Top module: `bus_retry_ctrl`

## Requirements
- R1: After reset both strobes, `data_oe`, `grant_o`, `lock_o`, `retry_o`, `done_o` and `err_o` are low, and `halt_n_o` is high.
- R2: An accepted request raises `as_o`, then raises `ds_o` one clock later, and `ds_o` is never high without `as_o`. The bus attributes equal the request. `data_oe` is high only for a write and only while `as_o` is high. An acknowledge during the data phase gives a one-clock `done_o` pulse and drops both strobes.
- R3: Bus error and halt seen together during the data phase end the cycle. Both strobes go low, the attributes stay unchanged, and no cycle starts, even with a request pending, while either input is still asserted.
- R4: `as_o` rises again on the fourth rising edge after bus error and halt are both negated: two clocks of synchronizer, then a two-clock delay. The rerun uses identical address, function code, size, direction and write data. `retry_o` stays high from the termination until the rerun ends with an acknowledge. Retries of the same cycle repeat without limit.
- R5: Bus request, bus error and halt asserted in the same clock, with no lock active, make the controller raise `grant_o` before any rerun. While `grant_o` is high no strobe is active. The rerun starts only after bus request is negated and bus error and halt are negated.
- R6: A request with `req_lock` high raises `lock_o`. `lock_o` stays high between locked cycles and through their retries. `grant_o` never rises while `lock_o` is high. `lock_o` falls once the controller is idle with no locked request pending.
- R7: Halt without bus error lets the running cycle finish on its acknowledge. After that no new cycle starts. Strobes and `data_oe` stay low, and address, function code, size and direction keep their last values.
- R8: While halted, negating halt for one clock and then asserting it again runs exactly one pending cycle.
- R9: A bus error while `exc_busy` is high ends the cycle with `halt_n_o` low and both strobes low. Only reset leaves this state. `grant_o` still follows bus request.
- R10: A bus error without halt while `exc_busy` is low ends the cycle with a one-clock `err_o` pulse. `halt_n_o` stays high and later cycles run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_addr | input | AW | Request address |
| req_fc | input | 3 | Request function code |
| req_size | input | 2 | Request transfer size |
| req_write | input | 1 | Request is a write |
| req_wdata | input | DW | Request write data |
| req_lock | input | 1 | Request belongs to a locked read-modify-write sequence |
| exc_busy | input | 1 | Exception processing in progress |
| ext_ack | input | 1 | Port acknowledge |
| ext_berr | input | 1 | Bus error, asynchronous |
| ext_halt | input | 1 | Halt request, asynchronous |
| ext_br | input | 1 | External bus request, asynchronous |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_size | output | 2 | Bus transfer size |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_wdata | output | DW | Bus write data |
| data_oe | output | 1 | Data bus drive enable |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| lock_o | output | 1 | Locked sequence in progress |
| grant_o | output | 1 | Bus granted to external master |
| halt_n_o | output | 1 | Low after a double fault |
| retry_o | output | 1 | Current cycle is a retry |
| done_o | output | 1 | One-clock pulse: cycle acknowledged |
| err_o | output | 1 | One-clock pulse: cycle ended by bus error |

## Verification
Some properties are checked on every clock. The data strobe never appears without the address strobe, and no strobe is active while the bus is granted. The lock and the grant never overlap. The attributes stay frozen while a retry is pending, the data drive stays off outside a strobe, and the double-fault halt never lets go. Other behaviour only the directed scenarios can show: the exact fourth-edge restart after release, the grant-then-rerun ordering, the one-cycle single step, the finish-then-stop under halt, and unlimited retries.

// File: rtl/bus_retry_ctrl.sv
module bus_retry_ctrl #(
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int SYNC_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_fc,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_lock,
  input  logic          exc_busy,
  input  logic          ext_ack,
  input  logic          ext_berr,
  input  logic          ext_halt,
  input  logic          ext_br,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          data_oe,
  output logic          as_o,
  output logic          ds_o,
  output logic          lock_o,
  output logic          grant_o,
  output logic          halt_n_o,
  output logic          retry_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int CW = $clog2(SYNC_DLY + 1);

  typedef enum logic [7:0] {
    ST_IDLE = 8'h01, ST_ADR  = 8'h02, ST_DAT  = 8'h04, ST_FIN  = 8'h08,
    ST_WREL = 8'h10, ST_GRNT = 8'h20, ST_STOP = 8'h40, ST_DFLT = 8'h80
  } st_t;

  st_t           st;
  logic [1:0]    berr_q, halt_q, br_q;
  logic          berr_s, halt_s, br_s, cap;
  logic [CW-1:0] cnt;
  logic          retry_q, lock_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      berr_q <= '0; halt_q <= '0; br_q <= '0;
    end else begin
      berr_q <= {berr_q[0], ext_berr};
      halt_q <= {halt_q[0], ext_halt};
      br_q   <= {br_q[0], ext_br};
    end

  assign berr_s = berr_q[1];
  assign halt_s = halt_q[1];
  assign br_s   = br_q[1];

  assign cap = req_valid && !halt_s &&
               ((st == ST_IDLE && !(br_s && !lock_q)) || st == ST_STOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_addr <= '0; bus_fc <= '0; bus_size <= '0;
      bus_write <= 1'b0; bus_wdata <= '0; lock_q <= 1'b0;
    end else if (cap) begin
      bus_addr <= req_addr; bus_fc <= req_fc; bus_size <= req_size;
      bus_write <= req_write; bus_wdata <= req_wdata; lock_q <= req_lock;
    end else if ((st == ST_IDLE && !(req_valid && req_lock)) || st == ST_DFLT) begin
      lock_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; retry_q <= 1'b0;
      done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        ST_IDLE:
          if (halt_s)              st <= ST_STOP;
          else if (br_s && !lock_q) st <= ST_GRNT;
          else if (req_valid)      st <= ST_ADR;
        ST_ADR: st <= ST_DAT;
        ST_DAT:
          if (berr_s && halt_s) begin
            retry_q <= 1'b1;
            st      <= (br_s && !lock_q) ? ST_GRNT : ST_WREL;
          end else if (berr_s) begin
            if (exc_busy) st <= ST_DFLT;
            else begin
              err_o <= 1'b1; retry_q <= 1'b0; st <= ST_FIN;
            end
          end else if (ext_ack) begin
            done_o <= 1'b1; retry_q <= 1'b0; st <= ST_FIN;
          end
        ST_FIN: if (!ext_ack) st <= ST_IDLE;
        ST_WREL:
          if (br_s && !lock_q) begin
            cnt <= '0; st <= ST_GRNT;
          end else if (berr_s || halt_s) cnt <= '0;
          else if (cnt == CW'(SYNC_DLY - 1)) begin
            cnt <= '0; st <= ST_ADR;
          end else cnt <= cnt + 1'b1;
        ST_GRNT: if (!br_s) st <= retry_q ? ST_WREL : ST_IDLE;
        ST_STOP: if (!halt_s) st <= req_valid ? ST_ADR : ST_IDLE;
        ST_DFLT: st <= ST_DFLT;
        default: st <= ST_IDLE;
      endcase
    end

  assign as_o     = (st == ST_ADR) || (st == ST_DAT);
  assign ds_o     = (st == ST_DAT);
  assign data_oe  = as_o && bus_write;
  assign lock_o   = lock_q;
  assign retry_o  = retry_q;
  assign halt_n_o = (st != ST_DFLT);
  assign grant_o  = (st == ST_GRNT) || (st == ST_DFLT && br_s && !lock_q);

  AST_DS_WITH_AS:      assert property (@(posedge clk) disable iff (!rst_n) ds_o |-> as_o); // R2
  AST_HIZ_OFF_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) !as_o |-> !data_oe); // R7
  AST_RETRY_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |=> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_size) &&
                 $stable(bus_write) && $stable(bus_wdata))); // R4
  AST_GRANT_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) grant_o |-> (!as_o && !ds_o)); // R5
  AST_LOCK_NO_GRANT:   assert property (@(posedge clk) disable iff (!rst_n) lock_o |-> !grant_o); // R6
  AST_DFLT_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) !halt_n_o |=> !halt_n_o); // R9
  AST_DFLT_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) !halt_n_o |-> !as_o); // R9
endmodule

// File: tb/bus_retry_ctrl_tb.sv
`timescale 1ns/1ps
module bus_retry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_lock = 0, exc_busy = 0;
  logic [23:0] req_addr = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_wdata = '0;
  logic        ext_ack = 0, ext_berr = 0, ext_halt = 0, ext_br = 0;
  logic [23:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_size;
  logic        bus_write;
  logic [15:0] bus_wdata;
  logic        data_oe, as_o, ds_o, lock_o, grant_o, halt_n_o, retry_o, done_o, err_o;

  int n_chk = 0, n_err = 0, mon_err = 0, as_cnt = 0;
  bit as_prev = 0, ack_mode = 0, finished = 0;

  always #2.5 clk = ~clk;

  bus_retry_ctrl #(.AW(24), .DW(16), .SYNC_DLY(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fc(req_fc), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_lock(req_lock), .exc_busy(exc_busy),
    .ext_ack(ext_ack), .ext_berr(ext_berr), .ext_halt(ext_halt), .ext_br(ext_br),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .data_oe(data_oe),
    .as_o(as_o), .ds_o(ds_o), .lock_o(lock_o), .grant_o(grant_o),
    .halt_n_o(halt_n_o), .retry_o(retry_o), .done_o(done_o), .err_o(err_o));

  always @(negedge clk) begin
    #1;
    ext_ack = ack_mode && ds_o;
    if (as_o && !as_prev) as_cnt++;
    as_prev = as_o;
    if (rst_n && grant_o && (as_o || ds_o)) begin
      mon_err++;
      $display("FAIL R5: strobe active while granted, actual as=%0b ds=%0b expected 0", as_o, ds_o);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_req(input logic [23:0] a, input logic [2:0] f, input logic [1:0] s,
                         input logic w, input logic [15:0] d, input logic lk);
    req_addr = a; req_fc = f; req_size = s; req_write = w; req_wdata = d; req_lock = lk;
    req_valid = 1'b1;
  endtask

  task automatic wait_as(input string tag);
    for (int n = 0; n < 40 && !as_o; n++) @(negedge clk);
    chk(tag, as_o, 1);
  endtask

  task automatic wait_ds(input string tag);
    for (int n = 0; n < 40 && !ds_o; n++) @(negedge clk);
    chk(tag, ds_o, 1);
  endtask

  task automatic wait_no_as(input string tag);
    for (int n = 0; n < 40 && as_o; n++) @(negedge clk);
    chk(tag, as_o, 0);
  endtask

  task automatic wait_done(input string tag);
    for (int n = 0; n < 40 && !done_o; n++) @(negedge clk);
    chk(tag, done_o, 1);
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0; req_lock = 0; exc_busy = 0;
    ext_berr = 0; ext_halt = 0; ext_br = 0; ack_mode = 0;
    tick(3);
    rst_n = 1;
    tick(2);
  endtask

  task automatic t_reset();
    chk("R1 as", as_o, 0);         chk("R1 ds", ds_o, 0);
    chk("R1 data_oe", data_oe, 0); chk("R1 grant", grant_o, 0);
    chk("R1 lock", lock_o, 0);     chk("R1 retry", retry_o, 0);
    chk("R1 halt_n", halt_n_o, 1); chk("R1 done/err", {done_o, err_o}, 0);
  endtask

  task automatic t_normal();
    put_req(24'h012340, 3'd5, 2'd2, 1'b1, 16'hBEEF, 1'b0);
    ack_mode = 1;
    wait_as("R2 write strobe");
    req_valid = 0;
    chk("R2 ds follows", ds_o, 0);
    chk("R2 addr", bus_addr, 24'h012340);
    chk("R2 fc/size/dir", {bus_fc, bus_size, bus_write}, {3'd5, 2'd2, 1'b1});
    chk("R2 wdata", bus_wdata, 16'hBEEF);
    chk("R2 data_oe write", data_oe, 1);
    tick(1);
    chk("R2 ds second clock", ds_o, 1);
    wait_done("R2 write done");
    tick(2);
    chk("R2 strobes off", {as_o, ds_o, data_oe}, 0);
    put_req(24'h000100, 3'd1, 2'd1, 1'b0, 16'h0, 1'b0);
    wait_as("R2 read strobe");
    req_valid = 0;
    chk("R2 data_oe read", data_oe, 0);
    wait_done("R2 read done");
  endtask

  task automatic t_retry();
    int snap;
    ack_mode = 0;
    put_req(24'h0A5500, 3'd2, 2'd1, 1'b1, 16'h1234, 1'b0);
    wait_ds("R3 data phase");
    req_valid = 0;
    ext_berr = 1; ext_halt = 1;
    wait_no_as("R3 strobes drop");
    chk("R3 ds low", ds_o, 0);
    chk("R4 retry flag", retry_o, 1);
    chk("R3 attr held", bus_addr, 24'h0A5500);
    put_req(24'h0B0000, 3'd1, 2'd0, 1'b0, 16'h0, 1'b0);
    snap = as_cnt;
    tick(10);
    chk("R3 no cycle while held", as_cnt - snap, 0);
    for (int k = 0; k < 2; k++) begin
      ext_berr = 0; ext_halt = 0;
      tick(3);
      chk("R4 still in sync delay", as_o, 0);
      tick(1);
      chk("R4 rerun on fourth edge", as_o, 1);
      chk("R4 rerun addr", bus_addr, 24'h0A5500);
      chk("R4 rerun attrs", {bus_fc, bus_size, bus_write, bus_wdata},
          {3'd2, 2'd1, 1'b1, 16'h1234});
      chk("R4 retry flag on rerun", retry_o, 1);
      if (k == 0) begin
        wait_ds("R4 second data phase");
        ext_berr = 1; ext_halt = 1;
        wait_no_as("R4 second termination");
      end
    end
    ack_mode = 1;
    wait_done("R4 rerun completes");
    chk("R4 retry cleared", retry_o, 0);
    wait_as("R3 pending request afterwards");
    req_valid = 0;
    chk("R3 pending addr", bus_addr, 24'h0B0000);
    wait_done("R3 pending done");
  endtask

  task automatic t_grant();
    ack_mode = 0;
    put_req(24'h330004, 3'd6, 2'd2, 1'b0, 16'h0, 1'b0);
    wait_ds("R5 data phase");
    req_valid = 0;
    ext_br = 1; ext_berr = 1; ext_halt = 1;
    for (int n = 0; n < 10 && !grant_o; n++) @(negedge clk);
    chk("R5 grant first", grant_o, 1);
    chk("R5 no strobe at grant", as_o, 0);
    tick(5);
    chk("R5 grant held", grant_o, 1);
    ext_br = 0;
    tick(4);
    chk("R5 grant returned", grant_o, 0);
    tick(4);
    chk("R5 waits for berr/halt", as_o, 0);
    ext_berr = 0; ext_halt = 0;
    tick(4);
    chk("R5 rerun after release", as_o, 1);
    chk("R5 rerun attrs", {bus_addr, bus_fc, bus_size, bus_write},
        {24'h330004, 3'd6, 2'd2, 1'b0});
    chk("R5 retry flag", retry_o, 1);
    ack_mode = 1;
    wait_done("R5 rerun done");
  endtask

  task automatic t_lock();
    ack_mode = 1;
    put_req(24'h440000, 3'd5, 2'd0, 1'b0, 16'h0, 1'b1);
    wait_as("R6 locked read");
    chk("R6 lock high", lock_o, 1);
    wait_done("R6 read done");
    req_write = 1; req_wdata = 16'h00A5;
    chk("R6 lock between", lock_o, 1);
    wait_as("R6 locked write");
    chk("R6 write dir", bus_write, 1);
    ack_mode = 0;
    wait_ds("R6 write data phase");
    ext_br = 1; ext_berr = 1; ext_halt = 1;
    for (int n = 0; n < 10; n++) begin
      tick(1);
      chk("R6 no grant while locked", grant_o, 0);
      chk("R6 lock kept in retry", lock_o, 1);
    end
    ext_br = 0; ext_berr = 0; ext_halt = 0;
    tick(4);
    chk("R6 rerun start", as_o, 1);
    chk("R6 rerun attrs", {bus_addr, bus_write, bus_wdata}, {24'h440000, 1'b1, 16'h00A5});
    chk("R6 lock on rerun", {lock_o, retry_o}, 2'b11);
    ack_mode = 1;
    req_valid = 0; req_lock = 0;
    wait_done("R6 rerun done");
    tick(3);
    chk("R6 lock released", lock_o, 0);
  endtask

  task automatic t_halt();
    int snap;
    ack_mode = 0;
    put_req(24'h550010, 3'd1, 2'd1, 1'b0, 16'h0, 1'b0);
    wait_ds("R7 data phase");
    req_valid = 0;
    ext_halt = 1;
    tick(4);
    chk("R7 cycle not cut", ds_o, 1);
    ack_mode = 1;
    wait_done("R7 cycle finishes");
    put_req(24'h550020, 3'd3, 2'd2, 1'b1, 16'h5A5A, 1'b0);
    snap = as_cnt;
    tick(6);
    chk("R7 stopped strobes", {as_o, ds_o, data_oe}, 0);
    chk("R7 no new cycle", as_cnt - snap, 0);
    chk("R7 attrs held", {bus_addr, bus_fc, bus_size, bus_write},
        {24'h550010, 3'd1, 2'd1, 1'b0});
    for (int k = 0; k < 2; k++) begin
      snap = as_cnt;
      ext_halt = 0;
      tick(1);
      ext_halt = 1;
      tick(15);
      chk("R8 one step", as_cnt - snap, 1);
      chk("R8 stepped addr", bus_addr, 24'h550020);
    end
    snap = as_cnt;
    tick(10);
    chk("R8 no step without pulse", as_cnt - snap, 0);
    req_valid = 0;
    tick(1);
    ext_halt = 0;
    tick(5);
  endtask

  task automatic t_berr_alone();
    bit seen = 0;
    exc_busy = 0; ack_mode = 0;
    put_req(24'h660000, 3'd2, 2'd1, 1'b0, 16'h0, 1'b0);
    wait_ds("R10 data phase");
    req_valid = 0;
    ext_berr = 1;
    for (int n = 0; n < 10 && !seen; n++) begin
      @(negedge clk);
      seen = err_o;
    end
    chk("R10 err pulse", seen, 1);
    chk("R10 no halt", halt_n_o, 1);
    ext_berr = 0;
    tick(3);
    chk("R10 strobes off", as_o, 0);
    ack_mode = 1;
    put_req(24'h660002, 3'd2, 2'd1, 1'b0, 16'h0, 1'b0);
    wait_as("R10 next cycle");
    req_valid = 0;
    wait_done("R10 next done");
  endtask

  task automatic t_double();
    int snap;
    exc_busy = 1; ack_mode = 0;
    put_req(24'h770000, 3'd6, 2'd2, 1'b0, 16'h0, 1'b0);
    wait_ds("R9 data phase");
    req_valid = 0;
    ext_berr = 1;
    wait_no_as("R9 cycle ends");
    chk("R9 halt out low", halt_n_o, 0);
    ext_berr = 0; exc_busy = 0;
    put_req(24'h770004, 3'd6, 2'd2, 1'b0, 16'h0, 1'b0);
    snap = as_cnt;
    tick(10);
    chk("R9 no cycles", as_cnt - snap, 0);
    chk("R9 stays halted", halt_n_o, 0);
    ext_br = 1;
    tick(4);
    chk("R9 grant works", grant_o, 1);
    ext_br = 0;
    tick(4);
    chk("R9 grant drops", grant_o, 0);
    do_reset();
    chk("R9 reset clears", halt_n_o, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_normal();
    t_retry();
    t_grant();
    t_lock();
    t_halt();
    t_berr_alone();
    t_double();
    tick(2);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err + mon_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err + mon_err);
      $finish;
    end
  end
endmodule